// File: doc/BRIEF.md
# Device-Side DMA Receive Bridge

This block is the device end of a memory-to-device DMA transfer. Software programs a destination address, a byte count and a region select through a small register port, then writes the start bit. While a transfer runs and bytes remain, the bridge asserts a request toward the host DMA channel. It then takes the data the channel delivers as 32-byte bursts, each split into fixed-width beats. Every accepted beat is forwarded to a plain local write port, at an address that starts at the programmed destination and advances by one beat width per beat.

The remaining byte count drops by 32 at the end of each burst. Once it reaches zero the bridge clears its start bit by itself, emits a one-cycle completion event and latches that event in a sticky status bit. Software clears the status bit by writing one to it. Writing zero to the start bit aborts a transfer at once, with no completion event. The programmed destination stays readable afterwards, because a separate working pointer does the stepping. The region select only steers the write port and always reads back as zero.

Top module: `devdma_rx_bridge`

## Requirements
- R1: After reset, the control register (offset 0x08, bit 0) reads 0. The count (0x04), the destination (0x00) and the status (0x88, bit 0) read 0. The outputs dma_req, done_pulse and mem_we are low.
- R2: While idle, the destination at offset 0x00 reads back exactly as written. The count at offset 0x04 reads back as written with its low 5 bits forced to zero.
- R3: The region select at offset 0x84 always reads 0. Its written value (bit 0) drives mem_region.
- R4: Writing 1 to bit 0 of offset 0x08 starts a transfer. From the next cycle, dma_req is high while the count is nonzero. The count drops by 32 after each fourth accepted beat, since one burst is four 64-bit beats.
- R5: A beat accepted at a clock edge appears on the write port at the next edge: mem_we is high, mem_wdata is unchanged, and mem_addr starts at the destination and rises by 8 for each beat.
- R6: One cycle after the count reaches zero, the control bit reads 0 and done_pulse is high for exactly one cycle. Status bit 0 at 0x88 becomes 1, the count reads 0 and the destination keeps its programmed value.
- R7: Writing 0 to bit 0 of 0x08 during a transfer drops dma_req from the next cycle. It raises no done_pulse, leaves the remaining count readable and causes later beats to be ignored.
- R8: Writing 1 to bit 0 of 0x88 clears the status bit. Writing 0 there leaves it unchanged.
- R9: Beats offered while no transfer runs produce no write on the write port.
- R10: Writes to the destination or the count while a transfer runs are ignored.
- R11: Starting with a count of zero never raises dma_req and completes one cycle later with a done_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| dma_req | output | 1 | Request toward the host DMA channel |
| beat_valid | input | 1 | A data beat is offered in this cycle |
| beat_data | input | 64 | Beat payload |
| mem_we | output | 1 | Local write port enable |
| mem_addr | output | 32 | Local write address |
| mem_wdata | output | 64 | Local write data |
| mem_region | output | 1 | Region select for the local write |
| done_pulse | output | 1 | One-cycle completion event |

## Verification
If the beat index is wrong, the count drops after the wrong number of beats. That shows within one burst as a wrong count readback, and at the end as a completion that comes early or late. If the working pointer is corrupted, a wrong mem_addr appears on the very next write. A run flag that does not clear after a stop or at completion keeps dma_req high, or lets ignored beats reach the write port, one cycle after the offending edge. A sticky bit that does not clear, or does not set, is seen on the next status read.

// File: rtl/devdma_pkg.sv
package devdma_pkg;

  // Register byte offsets on the configuration port
  localparam logic [7:0] OFS_DEST   = 8'h00;
  localparam logic [7:0] OFS_COUNT  = 8'h04;
  localparam logic [7:0] OFS_CTRL   = 8'h08;
  localparam logic [7:0] OFS_REGION = 8'h84;
  localparam logic [7:0] OFS_STATUS = 8'h88;

  // Commands decoded from register writes toward the transfer engine
  typedef struct packed {
    logic start;
    logic stop;
    logic cnt_we;
  } xfer_cmd_t;

endpackage

// File: rtl/bridge_rst_sync.sv
module bridge_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bridge_regs.sv
module bridge_regs
  import devdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 32,
  parameter int REGION_W   = 1,
  parameter int ALIGN_BITS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [7:0]          cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic                run,
  input  logic [CNT_W-1:0]    count,
  input  logic                done_evt,
  output logic [ADDR_W-1:0]   dest,
  output logic [REGION_W-1:0] region,
  output xfer_cmd_t           cmd,
  output logic [CNT_W-1:0]    cnt_wval
);

  logic [ADDR_W-1:0]   dest_q, dest_n;
  logic [REGION_W-1:0] region_q, region_n;
  logic                sticky_q, sticky_n;
  logic                hit_dest, hit_count, hit_ctrl, hit_region, hit_status;

  always_comb begin
    hit_dest   = cfg_wr && (cfg_addr == OFS_DEST);
    hit_count  = cfg_wr && (cfg_addr == OFS_COUNT);
    hit_ctrl   = cfg_wr && (cfg_addr == OFS_CTRL);
    hit_region = cfg_wr && (cfg_addr == OFS_REGION);
    hit_status = cfg_wr && (cfg_addr == OFS_STATUS);
  end

  // Commands toward the transfer engine; programming is locked while running
  always_comb begin
    cmd.start  = hit_ctrl && cfg_wdata[0] && !run;
    cmd.stop   = hit_ctrl && !cfg_wdata[0];
    cmd.cnt_we = hit_count && !run;
    cnt_wval   = {cfg_wdata[CNT_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  end

  // Next state
  always_comb begin
    dest_n   = dest_q;
    region_n = region_q;
    sticky_n = sticky_q;
    if (hit_dest && !run) dest_n = cfg_wdata[ADDR_W-1:0];
    if (hit_region)       region_n = cfg_wdata[REGION_W-1:0];
    if (hit_status && cfg_wdata[0]) sticky_n = 1'b0;
    if (done_evt)         sticky_n = 1'b1;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q   <= '0;
      region_q <= '0;
      sticky_q <= 1'b0;
    end else begin
      dest_q   <= dest_n;
      region_q <= region_n;
      sticky_q <= sticky_n;
    end
  end

  // Read mux; the region select is write-only
  always_comb begin
    unique case (cfg_addr)
      OFS_DEST:   cfg_rdata = 32'(dest_q);
      OFS_COUNT:  cfg_rdata = 32'(count);
      OFS_CTRL:   cfg_rdata = {31'b0, run};
      OFS_STATUS: cfg_rdata = {31'b0, sticky_q};
      default:    cfg_rdata = 32'b0;
    endcase
  end

  assign dest   = dest_q;
  assign region = region_q;

endmodule

// File: rtl/bridge_xfer.sv
module bridge_xfer
  import devdma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 32,
  parameter int BEAT_W      = 64,
  parameter int BURST_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xfer_cmd_t         cmd,
  input  logic [CNT_W-1:0]  cnt_wval,
  input  logic [ADDR_W-1:0] dest,
  input  logic              beat_valid,
  input  logic [BEAT_W-1:0] beat_data,
  output logic              run,
  output logic [CNT_W-1:0]  count,
  output logic              dma_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BEAT_W-1:0] mem_wdata,
  output logic              done_pulse
);

  localparam int BEAT_BYTES = BEAT_W / 8;
  localparam int BEATS      = BURST_BYTES / BEAT_BYTES;
  localparam int IDX_W      = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic              run_q, run_n;
  logic [CNT_W-1:0]  count_q, count_n;
  logic [ADDR_W-1:0] ptr_q, ptr_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic              we_q, we_n;
  logic [ADDR_W-1:0] waddr_q, waddr_n;
  logic [BEAT_W-1:0] wdata_q;
  logic              done_q, done_n;
  logic              accept, last_beat, finish;

  always_comb begin
    accept = run_q && beat_valid && (count_q != '0) && !cmd.stop;
    finish = run_q && (count_q == '0) && !cmd.stop;
  end

  // Burst position: a single-beat burst needs no index
  generate
    if (BEATS > 1) begin : g_multi_beat
      always_comb begin
        last_beat = (idx_q == IDX_W'(BEATS - 1));
        idx_n     = idx_q;
        if (cmd.start)   idx_n = '0;
        else if (accept) idx_n = last_beat ? '0 : idx_q + 1'b1;
      end
    end else begin : g_single_beat
      always_comb begin
        last_beat = 1'b1;
        idx_n     = '0;
      end
    end
  endgenerate

  // Next state
  always_comb begin
    run_n   = run_q;
    count_n = count_q;
    ptr_n   = ptr_q;
    we_n    = accept;
    waddr_n = waddr_q;
    done_n  = finish;
    if (cmd.start)        run_n = 1'b1;
    if (cmd.stop)         run_n = 1'b0;
    if (finish)           run_n = 1'b0;
    if (cmd.cnt_we)       count_n = cnt_wval;
    else if (accept && last_beat)
                          count_n = count_q - CNT_W'(BURST_BYTES);
    if (cmd.start)        ptr_n = dest;
    else if (accept)      ptr_n = ptr_q + ADDR_W'(BEAT_BYTES);
    if (accept)           waddr_n = ptr_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      count_q <= '0;
      ptr_q   <= '0;
      idx_q   <= '0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      done_q  <= 1'b0;
    end else begin
      run_q   <= run_n;
      count_q <= count_n;
      ptr_q   <= ptr_n;
      idx_q   <= idx_n;
      we_q    <= we_n;
      waddr_q <= waddr_n;
      done_q  <= done_n;
    end
  end

  // Data path register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wdata_q <= '0;
    else if (accept) wdata_q <= beat_data;
  end

  assign run        = run_q;
  assign count      = count_q;
  assign dma_req    = run_q && (count_q != '0);
  assign mem_we     = we_q;
  assign mem_addr   = waddr_q;
  assign mem_wdata  = wdata_q;
  assign done_pulse = done_q;

endmodule

// File: rtl/devdma_rx_bridge.sv
module devdma_rx_bridge
  import devdma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 32,
  parameter int BEAT_W      = 64,
  parameter int BURST_BYTES = 32,
  parameter int REGION_W    = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [7:0]          cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  output logic                dma_req,
  input  logic                beat_valid,
  input  logic [BEAT_W-1:0]   beat_data,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [BEAT_W-1:0]   mem_wdata,
  output logic [REGION_W-1:0] mem_region,
  output logic                done_pulse
);

  localparam int ALIGN_BITS = $clog2(BURST_BYTES);

  logic              rst_sync_n;
  logic              run_w;
  logic [CNT_W-1:0]  count_w;
  logic [ADDR_W-1:0] dest_w;
  logic [CNT_W-1:0]  cnt_wval_w;
  xfer_cmd_t         cmd_w;

  bridge_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bridge_regs #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .REGION_W   (REGION_W),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .run       (run_w),
    .count     (count_w),
    .done_evt  (done_pulse),
    .dest      (dest_w),
    .region    (mem_region),
    .cmd       (cmd_w),
    .cnt_wval  (cnt_wval_w)
  );

  bridge_xfer #(
    .ADDR_W      (ADDR_W),
    .CNT_W       (CNT_W),
    .BEAT_W      (BEAT_W),
    .BURST_BYTES (BURST_BYTES)
  ) u_xfer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cmd        (cmd_w),
    .cnt_wval   (cnt_wval_w),
    .dest       (dest_w),
    .beat_valid (beat_valid),
    .beat_data  (beat_data),
    .run        (run_w),
    .count      (count_w),
    .dma_req    (dma_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .done_pulse (done_pulse)
  );

endmodule

// File: rtl/devdma_rx_bridge_chk.sv
module devdma_rx_bridge_chk #(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 32,
  parameter int BEAT_BYTES  = 8,
  parameter int BURST_BYTES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [7:0]        cfg_addr,
  input logic [31:0]       cfg_wdata,
  input logic              dma_req,
  input logic              beat_valid,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done_pulse,
  input logic              run,
  input logic [CNT_W-1:0]  count
);

  // R6: completion is a single-cycle event
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  // R6: completion follows an empty running transfer and clears the run flag
  a_r6_done_after_empty: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> ($past(run) && ($past(count) == '0) && !run));

  // R7: a stop write drops the request and suppresses completion
  a_r7_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (cfg_addr == 8'h08) && !cfg_wdata[0]) |=> (!dma_req && !done_pulse));

  // R4: while running, the count only moves down by one burst
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (count != $past(count)))
      |-> (($past(count) - count) == CNT_W'(BURST_BYTES)));

  // R5: back-to-back writes step by one beat width
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(BEAT_BYTES)));

  // R9: a write on the port always follows an offered beat
  a_r9_we_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(beat_valid));

endmodule

bind devdma_rx_bridge devdma_rx_bridge_chk #(
  .ADDR_W      (ADDR_W),
  .CNT_W       (CNT_W),
  .BEAT_BYTES  (BEAT_W / 8),
  .BURST_BYTES (BURST_BYTES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cfg_wr     (cfg_wr),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .dma_req    (dma_req),
  .beat_valid (beat_valid),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .done_pulse (done_pulse),
  .run        (run_w),
  .count      (count_w)
);

// File: tb/devdma_rx_bridge_tb.sv
module devdma_rx_bridge_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        dma_req;
  logic        beat_valid;
  logic [63:0] beat_data;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [0:0]  mem_region;
  logic        done_pulse;

  int total = 0;
  int bad   = 0;
  int nlog  = 0;
  int ndone = 0;
  bit finished = 0;
  logic [31:0] log_addr [0:63];
  logic [63:0] log_data [0:63];

  always #5 clk = ~clk;

  devdma_rx_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dma_req(dma_req),
    .beat_valid(beat_valid), .beat_data(beat_data), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_region(mem_region),
    .done_pulse(done_pulse)
  );

  // Write-port and event monitor, sampled just after each edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (mem_we && nlog < 64) begin
        log_addr[nlog] = mem_addr;
        log_data[nlog] = mem_wdata;
        nlog++;
      end
      if (done_pulse) ndone++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic send_beats(input int n, input logic [63:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      beat_valid = 1'b1; beat_data = base + 64'(i);
    end
    @(negedge clk);
    beat_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 dma_req", {63'b0, dma_req}, 64'd0);
    chk("R1 done_pulse", {63'b0, done_pulse}, 64'd0);
    chk("R1 mem_we", {63'b0, mem_we}, 64'd0);
    cfg_read(8'h08, d); chk("R1 ctrl", {32'b0, d}, 64'd0);
    cfg_read(8'h04, d); chk("R1 count", {32'b0, d}, 64'd0);
    cfg_read(8'h00, d); chk("R1 dest", {32'b0, d}, 64'd0);
    cfg_read(8'h88, d); chk("R1 status", {32'b0, d}, 64'd0);
  endtask

  task automatic t_program;
    logic [31:0] d;
    cfg_write(8'h00, 32'h0000_1000);
    cfg_write(8'h04, 32'h47);
    cfg_read(8'h00, d); chk("R2 dest readback", {32'b0, d}, 64'h1000);
    cfg_read(8'h04, d); chk("R2 count low bits masked", {32'b0, d}, 64'h40);
    cfg_write(8'h84, 32'h1);
    cfg_read(8'h84, d); chk("R3 region reads zero", {32'b0, d}, 64'd0);
    chk("R3 region drives port", {63'b0, mem_region}, 64'd1);
  endtask

  task automatic t_idle_beats;
    int n0 = nlog;
    send_beats(4, 64'hdead);
    repeat (2) @(negedge clk);
    chk("R9 idle beats ignored", 64'(nlog - n0), 64'd0);
  endtask

  task automatic t_full_transfer;
    logic [31:0] d;
    int n0 = nlog;
    int d0 = ndone;
    cfg_write(8'h08, 32'h1);
    chk("R4 request raised", {63'b0, dma_req}, 64'd1);
    send_beats(4, 64'h100);
    cfg_read(8'h04, d); chk("R4 count after one burst", {32'b0, d}, 64'd32);
    chk("R4 request held", {63'b0, dma_req}, 64'd1);
    send_beats(4, 64'h104);
    @(negedge clk);
    chk("R6 one done pulse", 64'(ndone - d0), 64'd1);
    chk("R6 request dropped", {63'b0, dma_req}, 64'd0);
    cfg_read(8'h08, d); chk("R6 ctrl self-clears", {32'b0, d}, 64'd0);
    cfg_read(8'h04, d); chk("R6 count zero", {32'b0, d}, 64'd0);
    cfg_read(8'h00, d); chk("R6 dest kept", {32'b0, d}, 64'h1000);
    cfg_read(8'h84, d); chk("R6 region reads zero", {32'b0, d}, 64'd0);
    cfg_read(8'h88, d); chk("R6 status set", {32'b0, d}, 64'd1);
    chk("R6 still one pulse", 64'(ndone - d0), 64'd1);
    chk("R5 write count", 64'(nlog - n0), 64'd8);
    for (int i = 0; i < 8; i++) begin
      chk("R5 write address", {32'b0, log_addr[n0 + i]}, 64'(32'h1000 + 32'(8 * i)));
      chk("R5 write data", log_data[n0 + i], 64'h100 + 64'(i));
    end
  endtask

  task automatic t_status_w1c;
    logic [31:0] d;
    cfg_write(8'h88, 32'h0);
    cfg_read(8'h88, d); chk("R8 write zero keeps status", {32'b0, d}, 64'd1);
    cfg_write(8'h88, 32'h1);
    cfg_read(8'h88, d); chk("R8 write one clears status", {32'b0, d}, 64'd0);
  endtask

  task automatic t_stop;
    logic [31:0] d;
    int n0, d0;
    cfg_write(8'h00, 32'h2000);
    cfg_write(8'h04, 32'd96);
    cfg_write(8'h08, 32'h1);
    n0 = nlog; d0 = ndone;
    send_beats(4, 64'h200);
    cfg_write(8'h08, 32'h0);
    chk("R7 request dropped", {63'b0, dma_req}, 64'd0);
    cfg_read(8'h04, d); chk("R7 remaining count", {32'b0, d}, 64'd64);
    cfg_read(8'h08, d); chk("R7 ctrl zero", {32'b0, d}, 64'd0);
    send_beats(4, 64'h300);
    repeat (3) @(negedge clk);
    chk("R7 later beats ignored", 64'(nlog - n0), 64'd4);
    chk("R7 no done pulse", 64'(ndone - d0), 64'd0);
    cfg_read(8'h88, d); chk("R7 status stays clear", {32'b0, d}, 64'd0);
  endtask

  task automatic t_locked;
    logic [31:0] d;
    int n0, d0;
    cfg_write(8'h00, 32'h3000);
    cfg_write(8'h04, 32'd32);
    cfg_write(8'h08, 32'h1);
    cfg_write(8'h00, 32'h5000);
    cfg_write(8'h04, 32'h40);
    cfg_read(8'h00, d); chk("R10 dest locked", {32'b0, d}, 64'h3000);
    cfg_read(8'h04, d); chk("R10 count locked", {32'b0, d}, 64'd32);
    n0 = nlog; d0 = ndone;
    send_beats(4, 64'h400);
    @(negedge clk);
    chk("R10 writes to locked dest", {32'b0, log_addr[n0]}, 64'h3000);
    chk("R10 completes", 64'(ndone - d0), 64'd1);
  endtask

  task automatic t_zero_count;
    logic [31:0] d;
    int d0;
    cfg_write(8'h04, 32'h0);
    d0 = ndone;
    cfg_write(8'h08, 32'h1);
    chk("R11 no request", {63'b0, dma_req}, 64'd0);
    @(negedge clk);
    chk("R11 done pulse", 64'(ndone - d0), 64'd1);
    chk("R11 still no request", {63'b0, dma_req}, 64'd0);
    cfg_read(8'h08, d); chk("R11 ctrl cleared", {32'b0, d}, 64'd0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    beat_valid = 1'b0; beat_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_program();
    t_idle_beats();
    t_full_transfer();
    t_status_w1c();
    t_stop();
    t_locked();
    t_zero_count();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule